// File: doc/BRIEF.md
# Program Counter and Address Register Path

This block is the address side of a small accumulator machine. It holds two registers: an address register whose contents drive the memory address, and a program counter. The controller loads them on alternate phases of a two-phase clock. Each register has its own active-low load strobe.

The address register takes its next value from an AND-OR selector with two select lines. One line passes the program counter and the other passes an external address taken from the data bus. When both lines are low the selector gives zero, and that zero is how the controller resets the machine. When both lines are high the selector gives the bitwise OR of the two sources. This combination has no legal use, and the bench treats it only as a defined outcome to check.

The program counter loads the address register plus one. A ripple chain of half adders forms the increment. The two most significant address bits leave the block as the opcode field. Clocking both strobes alternately after a zero load makes the address step by one for every phase pair.

Top module: `pc_addr_path`

## Requirements
- R1: While rst_n is low, and on the first edge after it rises with no strobe active, addr_o reads 0 and opcode_o reads 0.
- R2: With ld_adr_n low, sel_pc_i high and sel_data_i low, addr_o takes the program counter value at the next rising clk edge.
- R3: With ld_adr_n low, sel_data_i high and sel_pc_i low, addr_o takes data_i at the next rising edge.
- R4: With ld_adr_n low and both select lines low, addr_o becomes 0 at the next rising edge.
- R5: With ld_adr_n low and both select lines high, addr_o becomes program counter OR data_i at the next rising edge.
- R6: With ld_pc_n low, the program counter takes the address register value plus one at the next rising edge. The new value can be seen at addr_o through a later load under R2.
- R7: The increment wraps, so an address of 8'hFF gives a program counter of 8'h00.
- R8: A register whose strobe is high keeps its value, whatever the select lines and data_i do.
- R9: opcode_o[1] equals addr_o[7] and opcode_o[0] equals addr_o[6] at all times.
- R10: When both strobes are low on the same edge, each register loads from the other's value before that edge. The program counter gets the old address plus one, and the address register gets the selection made from the old program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the phases are given by the strobes |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| sel_pc_i | input | 1 | Select line that passes the program counter to the address register |
| sel_data_i | input | 1 | Select line that passes data_i to the address register |
| ld_pc_n | input | 1 | Active-low load strobe for the program counter |
| ld_adr_n | input | 1 | Active-low load strobe for the address register |
| data_i | input | 8 | External address from the data bus |
| addr_o | output | 8 | Address register contents |
| opcode_o | output | 2 | Top two address bits, used as the opcode |

## Verification
The bench steps the path from a zero load through a long counting run that passes 8'hFF. A carry chain that was cut short or did not wrap would show up as a skipped or stuck address there. It loads a data address and then lets the program counter resume from it, which catches a counter that keeps its own old count instead of reloading from the address. It also drives both select combinations that are not single-source. A selector that gave priority to one source instead of OR-ing, or that held its old value instead of forcing zero, gives the wrong address. Simultaneous strobes expose a design that passes the new address straight into the counter in the same cycle.

// File: rtl/pca_pkg.sv
package pca_pkg;

  parameter int unsigned PCA_AW  = 8;
  parameter int unsigned PCA_OPW = 2;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'b00,
    SRC_DATA = 2'b01,
    SRC_PC   = 2'b10,
    SRC_BOTH = 2'b11
  } src_e;

  function automatic src_e src_of(input logic sp, input logic sd);
    return src_e'({sp, sd});
  endfunction

endpackage

// File: rtl/pca_incr.sv
module pca_incr #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] carry;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_ha
    assign sum_o[i]   = a_i[i] ^ carry[i];
    assign carry[i+1] = a_i[i] & carry[i];
  end

  assign cout_o = carry[W];
endmodule

// File: rtl/pca_sel.sv
module pca_sel #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] data_i,
  input  logic         sel_pc_i,
  input  logic         sel_data_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_aoi
    assign y_o[i] = (pc_i[i] & sel_pc_i) | (data_i[i] & sel_data_i);
  end
endmodule

// File: rtl/pca_reg.sv
module pca_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (!ld_n) q_o <= d_i;
  end

  // R8: an idle strobe keeps the register
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(q_o));
endmodule

// File: rtl/pc_addr_path.sv
module pc_addr_path #(
  parameter int unsigned AW  = pca_pkg::PCA_AW,
  parameter int unsigned OPW = pca_pkg::PCA_OPW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_pc_i,
  input  logic          sel_data_i,
  input  logic          ld_pc_n,
  input  logic          ld_adr_n,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic [OPW-1:0] opcode_o
);
  import pca_pkg::*;

  localparam int unsigned OP_LSB = AW - OPW;

  logic [AW-1:0] pc_q, adr_q, sel_y, inc_y;
  logic          inc_cout;
  src_e          src;
  logic          wrap_evt;
  logic          adr_load_evt;

  pca_sel #(.W(AW)) u_sel (
    .pc_i(pc_q), .data_i(data_i), .sel_pc_i(sel_pc_i),
    .sel_data_i(sel_data_i), .y_o(sel_y));

  pca_incr #(.W(AW)) u_inc (
    .a_i(adr_q), .sum_o(inc_y), .cout_o(inc_cout));

  pca_reg #(.W(AW)) u_adr (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_adr_n), .d_i(sel_y), .q_o(adr_q));

  pca_reg #(.W(AW)) u_pc (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_pc_n), .d_i(inc_y), .q_o(pc_q));

  assign src          = src_of(sel_pc_i, sel_data_i);
  assign wrap_evt     = inc_cout & ~ld_pc_n;
  assign adr_load_evt = ~ld_adr_n;

  assign addr_o   = adr_q;
  assign opcode_o = adr_q[AW-1:OP_LSB];

  // R4: both selects low forces zero
  p_zero_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_load_evt && src == SRC_ZERO) |=> adr_q == '0);

  // R3: data-only select loads the external address
  p_data_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_load_evt && src == SRC_DATA) |=> adr_q == $past(data_i));

  // R2: PC-only select copies the counter
  p_pc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_load_evt && src == SRC_PC) |=> adr_q == $past(pc_q));

  // R6: counter reloads with address plus one
  p_pc_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_pc_n |=> pc_q == $past(adr_q) + 1'b1);

  // R7: carry out of the chain means the counter wraps to zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> pc_q == '0);
endmodule

// File: tb/tb_pc_addr_path.sv
module tb_pc_addr_path;
  localparam int AW = 8;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_pc_i = 1'b0, sel_data_i = 1'b0, ld_pc_n = 1'b1, ld_adr_n = 1'b1;
  logic [AW-1:0] data_i = '0;
  logic [AW-1:0] addr_o;
  logic [1:0]    opcode_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pc_addr_path dut (
    .clk(clk), .rst_n(rst_n), .sel_pc_i(sel_pc_i), .sel_data_i(sel_data_i),
    .ld_pc_n(ld_pc_n), .ld_adr_n(ld_adr_n), .data_i(data_i),
    .addr_o(addr_o), .opcode_o(opcode_o));

  // vector: {req, ld_adr_n, ld_pc_n, sel_pc, sel_data, data, expected addr}
  typedef struct packed {
    logic [7:0] req;
    logic       la_n;
    logic       lp_n;
    logic       sp;
    logic       sd;
    logic [7:0] data;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'd6,  1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00}, // R6 pc=1
    '{8'd2,  1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h01}, // R2
    '{8'd6,  1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h01}, // R6 pc=2
    '{8'd2,  1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h02}, // R2
    '{8'd3,  1'b0, 1'b1, 1'b0, 1'b1, 8'hC5, 8'hC5}, // R3, R9 opcode 3
    '{8'd6,  1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC5}, // R6 pc=C6
    '{8'd2,  1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hC6}, // R2 resume
    '{8'd8,  1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hC6}, // R8 hold
    '{8'd5,  1'b0, 1'b1, 1'b1, 1'b1, 8'h21, 8'hE7}, // R5 OR
    '{8'd4,  1'b0, 1'b1, 1'b0, 1'b0, 8'h77, 8'h00}, // R4 zero
    '{8'd6,  1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00}, // R6 pc=1
    '{8'd2,  1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h01}, // R2
    '{8'd10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 8'h80}, // R10 pc=old adr+1=2
    '{8'd10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h02}, // R10 observe pc
    '{8'd3,  1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'hFF}, // R3
    '{8'd7,  1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF}, // R7 pc wraps
    '{8'd7,  1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00}  // R7 observe 00
  };

  task automatic check(input int req, input logic [7:0] exp);
    checks++;
    if (addr_o !== exp || opcode_o !== exp[7:6]) begin
      failures++;
      $display("FAIL R%0d addr=%h opc=%b expected addr=%h opc=%b",
               req, addr_o, opcode_o, exp, exp[7:6]);
    end
  endtask

  task automatic step(input logic la, input logic lp, input logic sp,
                      input logic sd, input logic [7:0] d);
    @(negedge clk);
    ld_adr_n = la; ld_pc_n = lp; sel_pc_i = sp; sel_data_i = sd; data_i = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #20000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] model;
    repeat (3) @(posedge clk);
    #1;
    check(1, 8'h00); // R1 during reset
    @(negedge clk) rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'hAA);
    check(1, 8'h00); // R1 after release, R8

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].la_n, VEC[i].lp_n, VEC[i].sp, VEC[i].sd, VEC[i].data);
      check(int'(VEC[i].req), VEC[i].exp);
    end

    // R6 R7 R9: reset-then-count past the wrap
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check(4, 8'h00);
    model = 8'h00;
    for (int n = 0; n < 300; n++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
      step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
      model = (model == 8'hFF) ? 8'h00 : model + 8'd1;
      check(7, model);
    end

    // R1: reset in the middle of a run
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check(1, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    check(1, 8'h00); // counter cleared too

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule